// File: doc/BRIEF.md
# Feedback and Output Clock Divider Chain

This block sits behind the oscillator of a frequency synthesizer and produces two kinds of divided clock. A programmable feedback divider divides the oscillator clock by a 9-bit ratio M and returns a feedback clock to the phase comparator, so the loop settles with the oscillator at M times the reference. A second divider, fed either by the oscillator or (in bypass) directly by the reference clock, divides by 1, 2, 4 or 8. Its result drives several identical true/complement output pairs with an even duty cycle.

Ratio changes are accepted only at period boundaries, so a reprogramming never produces a shortened pulse. An active-high master reset holds both dividers and drives every output pair to its differential low state. The divide settings come from upstream configuration storage that reset does not touch. While reset is high, the block keeps loading the presented settings, so the first periods after release already use them. The feedback clock also serves as the divider tap for an external test multiplexer.

Top module: `clk_div_chain`

## Requirements
- R1: The feedback counter steps through 0 to M-1 on oscillator edges and restarts at 0. `fb_clk_o` is registered and is high exactly while the counter is below floor(M/2), so its period is M oscillator cycles.
- R2: A ratio of 0 or 1 on `m_i` is used as 2.
- R3: A new `m_i` value is taken only when the feedback counter wraps from M-1 to 0. A change in the middle of a period does not alter that period.
- R4: `n_i` selects the output ratio: code 0 divides by 1, code 1 by 2, code 2 by 4 and code 3 by 8. For codes 1 to 3, a free 3-bit phase counter advances on each source edge and the output is counter bit (code-1), which gives a 50% duty cycle.
- R5: With code 0, each true output follows the source clock level directly.
- R6: A new `n_i` value is taken only on the source edge where the 3-bit phase counter wraps from 7 to 0. At that edge every divided output is low.
- R7: While `mr_i` is high, `fb_clk_o` is low (from the next oscillator edge on), every true output is low and every complement output is high. Both counters are held at 0.
- R8: Settings presented on `m_i` and `n_i` while `mr_i` is high are the ones in force from the first edge after release.
- R9: All output pairs carry the same divided clock, and each complement output is the inverse of its true output.
- R10: With `bypass_i` high, the output divider runs on `ref_clk_i` instead of `osc_clk_i`. The feedback divider stays on the oscillator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Oscillator clock, feedback divider source |
| ref_clk_i | input | 1 | Reference clock, output divider source in bypass |
| bypass_i | input | 1 | 1 selects the reference for the output divider |
| mr_i | input | 1 | Active-high master reset |
| m_i | input | 9 | Feedback divide ratio |
| n_i | input | 2 | Output divide code |
| fb_clk_o | output | 1 | Feedback clock to the phase comparator and test mux |
| out_p_o | output | 2 | True outputs, one per pair |
| out_n_o | output | 2 | Complement outputs, one per pair |

## Verification
On every cycle, the assertions check that the feedback counter stays below the ratio and wraps back to zero, and that the stored ratio never falls under 2. They also check that neither stored ratio moves except at its own wrap. Only the bench scenarios can show that the output waveforms are right. Those scenarios cover the exact pulse widths for each output code, the pass-through of the source clock, the absence of runt pulses when settings change mid-period, the reset levels on every pair, and the switch to the reference clock in bypass. The bench compares them against its own model at both clock phases.

// File: rtl/clk_div_pkg.sv
package clk_div_pkg;
    localparam int unsigned M_W_DEF   = 9;
    localparam int unsigned N_W_DEF   = 2;
    localparam int unsigned PAIRS_DEF = 2;
    localparam int unsigned M_MIN     = 2;
endpackage

// File: rtl/clk_div_srcsel.sv
module clk_div_srcsel (
    input  logic osc_i,
    input  logic ref_i,
    input  logic sel_ref_i,
    output logic clk_o
);
    assign clk_o = sel_ref_i ? ref_i : osc_i;
endmodule

// File: rtl/clk_div_fb.sv
module clk_div_fb #(
    parameter int unsigned M_W = clk_div_pkg::M_W_DEF
) (
    input  logic           clk_i,
    input  logic           mr_i,
    input  logic [M_W-1:0] m_i,
    output logic           fb_o
);
    localparam logic [M_W-1:0] RATIO_MIN = M_W'(clk_div_pkg::M_MIN);
    localparam logic [M_W-1:0] ONE       = M_W'(1);

    typedef struct packed {
        logic [M_W-1:0] cnt;
        logic [M_W-1:0] m;
        logic           fb;
    } fb_state_t;

    fb_state_t st_d, st_q;

    function automatic logic [M_W-1:0] clamp_ratio(input logic [M_W-1:0] v);
        return (v < RATIO_MIN) ? RATIO_MIN : v;
    endfunction

    always_comb begin
        st_d = st_q;
        if (mr_i) begin
            st_d.cnt = '0;
            st_d.m   = clamp_ratio(m_i);
            st_d.fb  = 1'b0;
        end else begin
            if (st_q.cnt == st_q.m - ONE) begin
                st_d.cnt = '0;
                st_d.m   = clamp_ratio(m_i);
            end else begin
                st_d.cnt = st_q.cnt + ONE;
            end
            st_d.fb = (st_d.cnt < (st_d.m >> 1));
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign fb_o = st_q.fb;

    p_cnt_in_range_r1: assert property (@(posedge clk_i) disable iff (mr_i)
        st_q.cnt < st_q.m);

    p_cnt_wraps_r1: assert property (@(posedge clk_i) disable iff (mr_i)
        (st_q.cnt == st_q.m - ONE) |=> (st_q.cnt == '0));

    p_ratio_min_r2: assert property (@(posedge clk_i) disable iff (mr_i)
        st_q.m >= RATIO_MIN);

    p_ratio_hold_r3: assert property (@(posedge clk_i) disable iff (mr_i)
        (st_q.cnt != st_q.m - ONE) |=> $stable(st_q.m));
endmodule

// File: rtl/clk_div_out.sv
module clk_div_out #(
    parameter int unsigned N_W = clk_div_pkg::N_W_DEF
) (
    input  logic           clk_i,
    input  logic           mr_i,
    input  logic [N_W-1:0] n_i,
    output logic           div_o
);
    localparam int unsigned CNT_W = (1 << N_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [N_W-1:0]   n;
    } out_state_t;

    out_state_t st_d, st_q;
    logic       wrap;
    logic       tap;

    assign wrap = &st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (mr_i) begin
            st_d.cnt = '0;
            st_d.n   = n_i;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (wrap) begin
                st_d.n = n_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    always_comb begin
        tap = 1'b0;
        for (int k = 1; k <= CNT_W; k++) begin
            if (st_q.n == N_W'(k)) begin
                tap = st_q.cnt[k-1];
            end
        end
    end

    assign div_o = mr_i ? 1'b0 : ((st_q.n == '0) ? clk_i : tap);

    p_code_hold_r6: assert property (@(posedge clk_i) disable iff (mr_i)
        !wrap |=> $stable(st_q.n));

    p_phase_advance_r4: assert property (@(posedge clk_i) disable iff (mr_i)
        !wrap |=> (st_q.cnt == $past(st_q.cnt) + CNT_W'(1)));
endmodule

// File: rtl/clk_div_chain.sv
module clk_div_chain #(
    parameter int unsigned M_W   = clk_div_pkg::M_W_DEF,
    parameter int unsigned N_W   = clk_div_pkg::N_W_DEF,
    parameter int unsigned PAIRS = clk_div_pkg::PAIRS_DEF
) (
    input  logic             osc_clk_i,
    input  logic             ref_clk_i,
    input  logic             bypass_i,
    input  logic             mr_i,
    input  logic [M_W-1:0]   m_i,
    input  logic [N_W-1:0]   n_i,
    output logic             fb_clk_o,
    output logic [PAIRS-1:0] out_p_o,
    output logic [PAIRS-1:0] out_n_o
);
    logic src_clk;
    logic div_clk;

    clk_div_srcsel u_srcsel (
        .osc_i     (osc_clk_i),
        .ref_i     (ref_clk_i),
        .sel_ref_i (bypass_i),
        .clk_o     (src_clk)
    );

    clk_div_fb #(.M_W(M_W)) u_fb (
        .clk_i (osc_clk_i),
        .mr_i  (mr_i),
        .m_i   (m_i),
        .fb_o  (fb_clk_o)
    );

    clk_div_out #(.N_W(N_W)) u_out (
        .clk_i (src_clk),
        .mr_i  (mr_i),
        .n_i   (n_i),
        .div_o (div_clk)
    );

    for (genvar g = 0; g < PAIRS; g++) begin : g_pair
        assign out_p_o[g] = div_clk;
        assign out_n_o[g] = ~div_clk;
    end
endmodule

// File: tb/clk_div_chain_tb_top.sv
module clk_div_chain_tb_top;
    logic       osc_clk = 1'b0;
    logic       ref_clk = 1'b0;
    logic       bypass  = 1'b0;
    logic       mr      = 1'b1;
    logic [8:0] m_in    = 9'd10;
    logic [1:0] n_in    = 2'd0;
    logic       fb_clk;
    logic [1:0] out_p;
    logic [1:0] out_n;

    int nchk = 0;
    int nerr = 0;
    int cycles = 0;
    string otag = "R7";
    string ftag = "R7";

    int fm_cnt = 0, fm_m = 2, fm_fb = 0;
    int om_cnt = 0, om_n = 0;

    clk_div_chain dut_i (
        .osc_clk_i (osc_clk),
        .ref_clk_i (ref_clk),
        .bypass_i  (bypass),
        .mr_i      (mr),
        .m_i       (m_in),
        .n_i       (n_in),
        .fb_clk_o  (fb_clk),
        .out_p_o   (out_p),
        .out_n_o   (out_n)
    );

    always #4 osc_clk = ~osc_clk;
    initial begin
        #3;
        forever #10 ref_clk = ~ref_clk;
    end

    function automatic int clampm(int v);
        return (v < 2) ? 2 : v;
    endfunction

    task automatic chk(logic act, logic exp, string req, string what);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic fb_step();
        if (mr) begin
            fm_cnt = 0; fm_m = clampm(int'(m_in)); fm_fb = 0;
        end else begin
            if (fm_cnt == fm_m - 1) begin
                fm_cnt = 0; fm_m = clampm(int'(m_in));
            end else begin
                fm_cnt++;
            end
            fm_fb = (fm_cnt < fm_m / 2) ? 1 : 0;
        end
    endtask

    task automatic out_step();
        if (mr) begin
            om_cnt = 0; om_n = int'(n_in);
        end else begin
            if (om_cnt == 7) begin
                om_cnt = 0; om_n = int'(n_in);
            end else begin
                om_cnt++;
            end
        end
    endtask

    task automatic cmp_outs(logic lvl);
        logic e;
        if (mr)            e = 1'b0;
        else if (om_n == 0) e = lvl;
        else               e = logic'((om_cnt >> (om_n - 1)) & 1);
        chk(out_p[0], e, otag, "out_p[0]");
        chk(out_n[0], ~e, "R7", "out_n[0]");
        chk(out_p[1], out_p[0], "R9", "out_p[1] vs pair 0");
        chk(out_n[1], ~out_p[1], "R9", "out_n[1] complement");
    endtask

    always @(posedge osc_clk) begin
        fb_step();
        if (!bypass) out_step();
        #2;
        chk(fb_clk, logic'(fm_fb), ftag, "fb_clk");
        if (!bypass) cmp_outs(1'b1);
        #4;
        if (!bypass) cmp_outs(1'b0);
    end

    always @(posedge ref_clk) begin
        if (bypass) out_step();
        #3;
        if (bypass) cmp_outs(1'b1);
        #10;
        if (bypass) cmp_outs(1'b0);
    end

    task automatic step(int k);
        repeat (k) @(posedge osc_clk);
        #7;
    endtask

    always @(posedge osc_clk) begin
        cycles++;
        if (cycles > 150000) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        step(6);
        otag = "R5"; ftag = "R1"; mr = 1'b0;
        step(40);
        otag = "R4"; n_in = 2'd1; step(40);
        n_in = 2'd2; step(40);
        n_in = 2'd3; step(50);
        otag = "R6"; n_in = 2'd1; step(3);
        n_in = 2'd2; step(5);
        n_in = 2'd0; step(30);
        ftag = "R3"; m_in = 9'd3; step(20);
        ftag = "R2"; m_in = 9'd0; step(20);
        m_in = 9'd1; step(20);
        ftag = "R3"; m_in = 9'd37; step(80);
        otag = "R7"; ftag = "R7"; n_in = 2'd3; mr = 1'b1; step(10);
        m_in = 9'd6; n_in = 2'd2; step(3);
        otag = "R8"; ftag = "R8"; mr = 1'b0; step(40);
        otag = "R7"; mr = 1'b1; bypass = 1'b1; step(6);
        otag = "R10"; ftag = "R1"; mr = 1'b0; n_in = 2'd1; step(60);
        n_in = 2'd0; step(40);
        n_in = 2'd3; step(80);
        otag = "R7"; mr = 1'b1; bypass = 1'b0; step(6);
        otag = "R4"; mr = 1'b0; step(20);
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule